// File: doc/BRIEF.md
# Asynchronous SRAM Access Controller

This block sits between a clocked host and an external asynchronous static RAM of 2,097,152 sixteen-bit words. The host offers one word access at a time on a valid/ready port. Each request carries a 21-bit word address, write data, a two-bit lane mask and a write flag. The controller turns each request into a strobe sequence on the memory pins. Every phase of that sequence lasts a whole number of clock cycles.

The memory is selected only while both chip enables agree: the active-low one is low and the active-high one is high. Two lane enables pick the low byte (bits 7:0) and the high byte (bits 15:8). The cycle counts come from the clock period and the memory's nanosecond limits, rounded up. The write pulse is also made longer than the output float time plus the data setup time. Read data comes back in a register with a one-cycle valid pulse.

The controller drives the shared data bus only while the write strobe is low. When a write follows a read, it first waits out the memory's output float time.

Top module: `sram_async_ctrl`

## Requirements
- R1: After reset, req_ready is high and rsp_valid is low. The memory is deselected (mem_ce_n=1, mem_ce=0). mem_we_n, mem_oe_n, mem_lo_n and mem_hi_n are all high.
- R2: mem_ce_n is low and mem_ce is high throughout every access. Whenever req_ready is high, the memory is deselected and both mem_we_n and mem_oe_n are high.
- R3: A read holds mem_oe_n low and mem_we_n high for 7 cycles (default parameters). The bus is captured on the last of those cycles. rsp_valid is high for exactly the one cycle after the last, and rsp_rdata is valid in that cycle.
- R4: A write holds mem_we_n low for 6 cycles with mem_oe_n high. The write data is on mem_dq throughout that pulse. One more cycle follows with mem_we_n high, the memory still selected and the address unchanged.
- R5: req_be bit 0 enables the low lane (mem_lo_n low) and bit 1 enables the high lane (mem_hi_n low). A lane whose mask bit is 0 stays high, so the memory keeps that byte during a write.
- R6: On a read, the byte of rsp_rdata that belongs to a masked-off lane is zero.
- R7: A write after a read, however long afterwards, first spends 3 cycles selected with mem_we_n and mem_oe_n both high before mem_we_n falls. A write that follows a write does not wait.
- R8: req_ready goes low in the cycle after acceptance and returns high when the cycle ends. The busy span is 7 cycles for a read, 7 for a write, and 10 for a write after a read.
- R9: mem_addr, mem_lo_n and mem_hi_n do not change while the memory is selected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller idle, request taken this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 21 | Word address |
| req_wdata | input | 16 | Write data |
| req_be | input | 2 | Lane mask, bit 0 low byte, bit 1 high byte |
| rsp_valid | output | 1 | One-cycle read data strobe |
| rsp_rdata | output | 16 | Read data, masked lanes zero |
| mem_addr | output | 21 | Memory address |
| mem_ce_n | output | 1 | Chip enable, active low |
| mem_ce | output | 1 | Chip enable, active high |
| mem_we_n | output | 1 | Write strobe, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_lo_n | output | 1 | Low byte lane enable, active low |
| mem_hi_n | output | 1 | High byte lane enable, active low |
| mem_dq | inout | 16 | Memory data bus |

## Verification
The hardest case to reach is the turnaround rule. It depends on history: the last completed access must have been a read, no write may have started since, and an arbitrary idle gap may lie between them. The directed sequence reaches it by interleaving reads and writes. It then counts the selected cycles with both strobes high ahead of the write pulse, and checks that two writes in a row carry no such gap. Lane masking is checked the same way: a partial write is read back in full, and the same word is read again under each single-lane mask.

// File: rtl/sram_async_ctrl.sv
module sram_async_ctrl #(
  parameter int ADDR_W  = 21,
  parameter int DATA_W  = 16,
  parameter int CLK_NS  = 10,
  parameter int T_RC_NS = 70,
  parameter int T_AA_NS = 70,
  parameter int T_WC_NS = 70,
  parameter int T_WP_NS = 55,
  parameter int T_DW_NS = 30,
  parameter int T_HZ_NS = 25
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [1:0]        req_be,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_ce_n,
  output logic              mem_ce,
  output logic              mem_we_n,
  output logic              mem_oe_n,
  output logic              mem_lo_n,
  output logic              mem_hi_n,
  inout  wire  [DATA_W-1:0] mem_dq
);
  localparam int LANE_W  = DATA_W / 2;
  localparam int RC_CYC  = (T_RC_NS + CLK_NS - 1) / CLK_NS;
  localparam int AA_CYC  = (T_AA_NS + CLK_NS - 1) / CLK_NS;
  localparam int RD_CYC  = (RC_CYC > AA_CYC) ? RC_CYC : AA_CYC;
  localparam int WPM_CYC = (T_WP_NS + CLK_NS - 1) / CLK_NS;
  localparam int WPT_CYC = (T_HZ_NS + T_DW_NS) / CLK_NS + 1;
  localparam int WP_CYC  = (WPM_CYC > WPT_CYC) ? WPM_CYC : WPT_CYC;
  localparam int HZ_CYC  = (T_HZ_NS + CLK_NS - 1) / CLK_NS;
  localparam int TA_CYC  = (HZ_CYC > 1) ? HZ_CYC : 1;
  localparam int WC_CYC  = (T_WC_NS + CLK_NS - 1) / CLK_NS;
  localparam int REC_CYC = (WC_CYC - WP_CYC > 1) ? (WC_CYC - WP_CYC) : 1;
  localparam int M1      = (RD_CYC > WP_CYC) ? RD_CYC : WP_CYC;
  localparam int M2      = (TA_CYC > REC_CYC) ? TA_CYC : REC_CYC;
  localparam int MAXC    = (M1 > M2) ? M1 : M2;
  localparam int CNT_W   = $clog2(MAXC + 1);

  typedef enum logic [2:0] {S_IDLE, S_TURN, S_WR, S_REC, S_RD} state_t;

  state_t            st;
  logic [CNT_W-1:0]  cnt;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic [1:0]        be_q;
  logic              after_rd;
  logic [DATA_W-1:0] rdata_q;
  logic              rsp_q;
  logic              active;
  logic [DATA_W-1:0] rd_masked;

  assign active    = (st != S_IDLE);
  assign req_ready = !active;
  assign rsp_valid = rsp_q;
  assign rsp_rdata = rdata_q;
  assign mem_addr  = addr_q;
  assign mem_ce_n  = !active;
  assign mem_ce    = active;
  assign mem_we_n  = (st != S_WR);
  assign mem_oe_n  = (st != S_RD);
  assign mem_lo_n  = !(active && be_q[0]);
  assign mem_hi_n  = !(active && be_q[1]);
  assign mem_dq    = (st == S_WR) ? wdata_q : {DATA_W{1'bz}};
  assign rd_masked = mem_dq & {{LANE_W{be_q[1]}}, {LANE_W{be_q[0]}}};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      cnt      <= '0;
      addr_q   <= '0;
      wdata_q  <= '0;
      be_q     <= '0;
      after_rd <= 1'b0;
      rdata_q  <= '0;
      rsp_q    <= 1'b0;
    end else begin
      rsp_q <= 1'b0;
      case (st)
        S_IDLE: if (req_valid) begin
          addr_q  <= req_addr;
          wdata_q <= req_wdata;
          be_q    <= req_be;
          if (!req_write) begin
            st  <= S_RD;
            cnt <= CNT_W'(RD_CYC - 1);
          end else if (after_rd) begin
            st  <= S_TURN;
            cnt <= CNT_W'(TA_CYC - 1);
          end else begin
            st  <= S_WR;
            cnt <= CNT_W'(WP_CYC - 1);
          end
        end
        S_TURN: if (cnt == '0) begin
          st       <= S_WR;
          cnt      <= CNT_W'(WP_CYC - 1);
          after_rd <= 1'b0;
        end else cnt <= cnt - 1'b1;
        S_WR: if (cnt == '0) begin
          st  <= S_REC;
          cnt <= CNT_W'(REC_CYC - 1);
        end else cnt <= cnt - 1'b1;
        S_REC: if (cnt == '0) st <= S_IDLE;
               else cnt <= cnt - 1'b1;
        S_RD: if (cnt == '0) begin
          rdata_q  <= rd_masked;
          rsp_q    <= 1'b1;
          after_rd <= 1'b1;
          st       <= S_IDLE;
        end else cnt <= cnt - 1'b1;
        default: st <= S_IDLE;
      endcase
    end
  end

  AST_IDLE_DESELECT: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (mem_ce_n && !mem_ce && mem_we_n && mem_oe_n)); // R2
  AST_RSP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid); // R3
  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(!mem_we_n && !mem_oe_n)); // R4
  AST_WE_RISE_SELECTED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> (!mem_ce_n && $stable(mem_addr))); // R4
  AST_TURN_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_we_n) |-> $past(mem_oe_n)); // R7
  AST_READY_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready); // R8
  AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_ce_n && $past(!mem_ce_n)) |-> ($stable(mem_addr) && $stable(mem_lo_n) && $stable(mem_hi_n))); // R9
endmodule

// File: tb/sram_async_ctrl_tb_top.sv
module sram_async_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [20:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic [1:0]  req_be = '0;
  logic        req_ready, rsp_valid;
  logic [15:0] rsp_rdata;
  logic [20:0] mem_addr;
  logic        mem_ce_n, mem_ce, mem_we_n, mem_oe_n, mem_lo_n, mem_hi_n;
  wire  [15:0] mem_dq;

  int checks = 0;
  int fails = 0;

  always #2.5 clk = ~clk;

  sram_async_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .mem_addr(mem_addr),
    .mem_ce_n(mem_ce_n), .mem_ce(mem_ce), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n),
    .mem_lo_n(mem_lo_n), .mem_hi_n(mem_hi_n), .mem_dq(mem_dq)
  );

  logic [15:0] ram [256];
  logic        sel, rd_drive;
  assign sel      = !mem_ce_n && mem_ce;
  assign rd_drive = sel && !mem_oe_n && mem_we_n;
  assign mem_dq[7:0]  = (rd_drive && !mem_lo_n) ? ram[mem_addr[7:0]][7:0]  : 8'bz;
  assign mem_dq[15:8] = (rd_drive && !mem_hi_n) ? ram[mem_addr[7:0]][15:8] : 8'bz;

  always @(negedge clk) begin
    if (sel && !mem_we_n) begin
      if (!mem_lo_n) ram[mem_addr[7:0]][7:0]  <= mem_dq[7:0];
      if (!mem_hi_n) ram[mem_addr[7:0]][15:8] <= mem_dq[15:8];
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic t_reset_state();
    chk(req_ready && !rsp_valid, "R1 ready/rsp", {req_ready, rsp_valid}, 2'b10);
    chk(mem_ce_n && !mem_ce && mem_we_n && mem_oe_n && mem_lo_n && mem_hi_n,
        "R1 memory pins", {mem_ce_n, mem_ce, mem_we_n, mem_oe_n, mem_lo_n, mem_hi_n}, 6'b101111);
  endtask

  task automatic t_write(input logic [20:0] a, input logic [15:0] d, input logic [1:0] be,
                         input int exp_turn);
    int turn = 0, pulse = 0, rec = 0, busy = 0;
    bit sel_ok = 1, hold_ok = 1, lane_ok = 1, oe_ok = 1, data_ok = 1;
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d; req_be = be;
    chk(req_ready, "R8 ready before write", req_ready, 1);
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    while (!req_ready && busy < 50) begin
      busy++;
      if (!sel) sel_ok = 0;
      if (mem_addr != a) hold_ok = 0;
      if (mem_lo_n != !be[0] || mem_hi_n != !be[1]) lane_ok = 0;
      if (!mem_oe_n) oe_ok = 0;
      if (!mem_we_n) begin
        pulse++;
        if (mem_dq !== d) data_ok = 0;
      end else if (pulse == 0) turn++;
      else rec++;
      @(negedge clk);
    end
    chk(sel_ok, "R2 selected during write", sel_ok, 1);
    chk(hold_ok, "R9 address held in write", hold_ok, 1);
    chk(lane_ok, "R5 lane enables follow mask", lane_ok, 1);
    chk(oe_ok && data_ok, "R4 oe high, data driven in pulse", {oe_ok, data_ok}, 2'b11);
    chk(pulse == 6, "R4 write pulse length", pulse, 6);
    chk(rec == 1, "R4 recovery cycle", rec, 1);
    chk(turn == exp_turn, "R7 turnaround cycles", turn, exp_turn);
    chk(busy == exp_turn + 7, "R8 write busy span", busy, exp_turn + 7);
    chk(mem_ce_n && !mem_ce && mem_we_n && mem_oe_n, "R2 deselected when ready",
        {mem_ce_n, mem_ce, mem_we_n, mem_oe_n}, 4'b1011);
  endtask

  task automatic t_read(input logic [20:0] a, input logic [1:0] be, input logic [15:0] exp);
    int oe_low = 0, busy = 0;
    bit we_ok = 1, hold_ok = 1, rsp_early = 0;
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a; req_be = be; req_wdata = 16'h0;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    chk(!req_ready, "R8 ready low after read accept", req_ready, 0);
    while (!rsp_valid && busy < 50) begin
      busy++;
      if (!mem_oe_n) oe_low++;
      if (!mem_we_n || !sel) we_ok = 0;
      if (mem_addr != a || mem_lo_n != !be[0] || mem_hi_n != !be[1]) hold_ok = 0;
      if (req_ready) rsp_early = 1;
      @(negedge clk);
    end
    chk(oe_low == 7 && busy == 7, "R3 read strobe length", oe_low, 7);
    chk(we_ok, "R3 we high, selected during read", we_ok, 1);
    chk(hold_ok, "R9 address/lanes held in read", hold_ok, 1);
    chk(!rsp_early && req_ready, "R8 ready returns at read end", req_ready, 1);
    if (be == 2'b11) chk(rsp_rdata == exp, "R3 read data", rsp_rdata, exp);
    else chk(rsp_rdata == exp, "R6 masked lane reads zero", rsp_rdata, exp);
    @(negedge clk);
    chk(!rsp_valid, "R3 rsp_valid single pulse", rsp_valid, 0);
  endtask

  initial begin
    #(5.0 * 200000);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) ram[i] = 16'h0;
    #1;
    t_reset_state();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset_state();
    t_write(21'h000010, 16'h1234, 2'b11, 0);
    t_write(21'h000020, 16'hBEEF, 2'b11, 0);
    t_read(21'h000010, 2'b11, 16'h1234);
    repeat (5) @(negedge clk);
    t_write(21'h000010, 16'hFFFF, 2'b01, 3);
    t_read(21'h000010, 2'b11, 16'h12FF);
    t_read(21'h000010, 2'b10, 16'h1200);
    t_read(21'h000010, 2'b01, 16'h00FF);
    t_read(21'h000020, 2'b11, 16'hBEEF);
    t_write(21'h000020, 16'h55AA, 2'b10, 3);
    t_write(21'h1FFFFF, 16'hC3A5, 2'b11, 0);
    t_read(21'h000020, 2'b11, 16'h55EF);
    t_read(21'h1FFFFF, 2'b11, 16'hC3A5);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule